// File: doc/BRIEF.md
# Packed Two-Entry Color Palette

This block is a 256-entry color lookup table. Software fills it through a window of 128 words on the register bus. Each 32-bit word carries two 16-bit palette entries. Each entry holds three 5-bit color channels and one intensity flag. Software can read every word back exactly as it wrote it.

On the other side, the pixel unpacker presents an 8-bit entry number together with a valid strobe. One clock later the block returns a 24-bit color and a matching valid. Each 5-bit channel is widened to 8 bits by padding three zero bits at the bottom. The intensity flag plays no part in the color.

The lookup path is driven by a two-state sequencer:
- `LK_IDLE` means no result is pending.
- `LK_OUT` means a result is being presented.
- Transition `T_ISSUE` (any state to `LK_OUT`) fires whenever the pixel strobe is high.
- Transition `T_DRAIN` (any state to `LK_IDLE`) fires whenever the strobe is low.

Top module: `palette_lut`

## Requirements
- R1: While `rst_n` is low, all 128 stored words are zero and `pix_vld_o` is low. After reset, every bus read returns 0 and every lookup returns color 0 until a write happens.
- R2: When `bus_wr_en` is high at a clock edge, word `bus_wr_idx` takes the value `bus_wr_data` at that edge. When `bus_rd_en` is high at an edge, `bus_rd_data` shows the stored word at the following sample and holds it while `bus_rd_en` stays low. A read and a write to the same word in the same cycle return the old value.
- R3: Entry number `e` lives in word `e[7:1]`. An even `e` (bit 0 = 0) uses the low half-word `[15:0]`. An odd `e` uses the high half-word `[31:16]`.
- R4: Within a half-word, red is bits [4:0], green is bits [9:5] and blue is bits [14:10]. `pix_rgb_o` is {red, 3'b000, green, 3'b000, blue, 3'b000}, with red in bits [23:16], green in [15:8] and blue in [7:0].
- R5: Bit 15 of each half-word (the intensity flag) has no effect on `pix_rgb_o`. It is still returned unchanged by bus reads.
- R6: `pix_vld_o` equals `pix_vld_i` delayed by exactly one clock. `pix_rgb_o` changes only in the cycle after a valid request and otherwise holds its value.
- R7: A lookup presented in the cycle after a write to its word returns the new color. A lookup presented in the same cycle as that write returns the old color.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr_en | input | 1 | Window write strobe |
| bus_wr_idx | input | 7 | Word number of the write |
| bus_wr_data | input | 32 | Word to store (two packed entries) |
| bus_rd_en | input | 1 | Window read strobe |
| bus_rd_idx | input | 7 | Word number of the read |
| bus_rd_data | output | 32 | Raw word returned one clock after the strobe |
| pix_idx_i | input | 8 | Entry number from the pixel unpacker |
| pix_vld_i | input | 1 | Lookup request strobe |
| pix_rgb_o | output | 24 | Expanded color |
| pix_vld_o | output | 1 | Color valid, one clock after the request |

## Verification
The hardest case to reach is a collision: a lookup or a bus read that lands on a word in exactly the cycle that word is written, or in the very next cycle. This is what separates the old value from the new one (R7, R2). A directed sequence writes a word and looks up its entry in the same cycle, then again one cycle later. The random phase confines addresses to a few words for long stretches, so that writes, reads and lookups keep colliding with one another. Words with the intensity bit set in both halves are mixed in throughout, which shows that the flag reaches readback but never reaches the color.

// File: rtl/palette_lut_pkg.sv
package palette_lut_pkg;
    localparam int CH_W   = 5;
    localparam int OUT_CH = 8;
    localparam int HALF_W = 16;
    localparam int WORD_W = 2 * HALF_W;
    localparam int RGB_W  = 3 * OUT_CH;
    localparam int PAD_W  = OUT_CH - CH_W;
    localparam int RED_LO = 0;
    localparam int GRN_LO = CH_W;
    localparam int BLU_LO = 2 * CH_W;

    typedef enum logic {
        LK_IDLE = 1'b0,
        LK_OUT  = 1'b1
    } lk_state_t;
endpackage

// File: rtl/pal_word_store.sv
module pal_word_store #(
    parameter int WORDS = 128,
    parameter int AW    = 7,
    parameter int DW    = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    input  logic          lk_en,
    input  logic [AW-1:0] lk_addr,
    output logic [DW-1:0] lk_data
);
    logic [DW-1:0] mem [WORDS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= mem[rd_addr];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lk_data <= '0;
        end else if (lk_en) begin
            lk_data <= mem[lk_addr];
        end
    end
endmodule

// File: rtl/pal_half_expand.sv
module pal_half_expand
    import palette_lut_pkg::*;
(
    input  logic [HALF_W-1:0] half,
    output logic [RGB_W-1:0]  rgb
);
    logic [CH_W-1:0] red, grn, blu;

    always_comb begin
        red = half[RED_LO +: CH_W];
        grn = half[GRN_LO +: CH_W];
        blu = half[BLU_LO +: CH_W];
        rgb = {red, {PAD_W{1'b0}}, grn, {PAD_W{1'b0}}, blu, {PAD_W{1'b0}}};
    end
endmodule

// File: rtl/pal_lookup_ctl.sv
module pal_lookup_ctl
    import palette_lut_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_vld,
    input  logic req_half,
    output logic lk_en,
    output logic half_q,
    output logic out_vld
);
    lk_state_t state_q, state_d;

    always_comb begin
        unique case (state_q)
            LK_IDLE: state_d = req_vld ? LK_OUT : LK_IDLE;
            LK_OUT:  state_d = req_vld ? LK_OUT : LK_IDLE;
            default: state_d = LK_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LK_IDLE;
            half_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (req_vld) half_q <= req_half;
        end
    end

    always_comb begin
        lk_en   = req_vld;
        out_vld = (state_q == LK_OUT);
    end
endmodule

// File: rtl/palette_lut.sv
module palette_lut
    import palette_lut_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr_en,
    input  logic [IDX_W-2:0]      bus_wr_idx,
    input  logic [WORD_W-1:0]     bus_wr_data,
    input  logic                  bus_rd_en,
    input  logic [IDX_W-2:0]      bus_rd_idx,
    output logic [WORD_W-1:0]     bus_rd_data,
    input  logic [IDX_W-1:0]      pix_idx_i,
    input  logic                  pix_vld_i,
    output logic [RGB_W-1:0]      pix_rgb_o,
    output logic                  pix_vld_o
);
    localparam int WAW   = IDX_W - 1;
    localparam int WORDS = 1 << WAW;

    logic              lk_en;
    logic              half_q;
    logic [WORD_W-1:0] lk_word;
    logic [RGB_W-1:0]  half_rgb [2];

    pal_lookup_ctl u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_vld  (pix_vld_i),
        .req_half (pix_idx_i[0]),
        .lk_en    (lk_en),
        .half_q   (half_q),
        .out_vld  (pix_vld_o)
    );

    pal_word_store #(
        .WORDS (WORDS),
        .AW    (WAW),
        .DW    (WORD_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_wr_en),
        .wr_addr (bus_wr_idx),
        .wr_data (bus_wr_data),
        .rd_en   (bus_rd_en),
        .rd_addr (bus_rd_idx),
        .rd_data (bus_rd_data),
        .lk_en   (lk_en),
        .lk_addr (pix_idx_i[IDX_W-1:1]),
        .lk_data (lk_word)
    );

    for (genvar h = 0; h < 2; h++) begin : g_half
        pal_half_expand u_exp (
            .half (lk_word[h*HALF_W +: HALF_W]),
            .rgb  (half_rgb[h])
        );
    end

    assign pix_rgb_o = half_q ? half_rgb[1] : half_rgb[0];
endmodule

// File: rtl/palette_lut_chk.sv
module palette_lut_chk
    import palette_lut_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_rd_en,
    input logic [WORD_W-1:0] bus_rd_data,
    input logic              pix_vld_i,
    input logic [RGB_W-1:0]  pix_rgb_o,
    input logic              pix_vld_o
);
    always @(posedge clk) begin
        if (!rst_n) begin
            a_reset_quiet_r1: assert (!pix_vld_o && bus_rd_data == '0 && pix_rgb_o == '0);
        end
    end

    p_vld_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pix_vld_i |=> pix_vld_o);

    p_vld_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_vld_i |=> !pix_vld_o);

    p_rgb_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_vld_i |=> $stable(pix_rgb_o));

    p_pad_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pix_vld_o |-> (pix_rgb_o[2:0] == 3'b0 && pix_rgb_o[10:8] == 3'b0
                       && pix_rgb_o[18:16] == 3'b0));

    p_rdata_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_en |=> $stable(bus_rd_data));
endmodule

bind palette_lut palette_lut_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_rd_en   (bus_rd_en),
    .bus_rd_data (bus_rd_data),
    .pix_vld_i   (pix_vld_i),
    .pix_rgb_o   (pix_rgb_o),
    .pix_vld_o   (pix_vld_o)
);

// File: tb/palette_lut_bench.sv
`timescale 1ns/1ps
module palette_lut_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr_en = 1'b0;
    logic [6:0]  bus_wr_idx = '0;
    logic [31:0] bus_wr_data = '0;
    logic        bus_rd_en = 1'b0;
    logic [6:0]  bus_rd_idx = '0;
    logic [31:0] bus_rd_data;
    logic [7:0]  pix_idx_i = '0;
    logic        pix_vld_i = 1'b0;
    logic [23:0] pix_rgb_o;
    logic        pix_vld_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    palette_lut u_palette_lut (
        .clk (clk), .rst_n (rst_n),
        .bus_wr_en (bus_wr_en), .bus_wr_idx (bus_wr_idx), .bus_wr_data (bus_wr_data),
        .bus_rd_en (bus_rd_en), .bus_rd_idx (bus_rd_idx), .bus_rd_data (bus_rd_data),
        .pix_idx_i (pix_idx_i), .pix_vld_i (pix_vld_i),
        .pix_rgb_o (pix_rgb_o), .pix_vld_o (pix_vld_o)
    );

    // Reference model: plain words, colors computed arithmetically.
    int unsigned raw [128];
    int unsigned exp_rd = 0;
    int unsigned exp_rgb = 0;
    bit          exp_vld = 0;

    function automatic int unsigned color_of(int unsigned w, bit odd);
        int unsigned h = odd ? (w >> 16) : (w & 32'h0000_FFFF);
        int unsigned r = (h % 32) * 8;
        int unsigned g = ((h / 32) % 32) * 8;
        int unsigned b = ((h / 1024) % 32) * 8;
        return r * 65536 + g * 256 + b;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (raw[i]) raw[i] = 0;
            exp_rd = 0; exp_rgb = 0; exp_vld = 0;
        end else begin
            exp_vld = pix_vld_i;
            if (pix_vld_i) exp_rgb = color_of(raw[pix_idx_i / 2], pix_idx_i[0]);
            if (bus_rd_en) exp_rd = raw[bus_rd_idx];
            if (bus_wr_en) raw[bus_wr_idx] = bus_wr_data;
        end
    end

    task automatic check(bit ok, string req, int unsigned act, int unsigned expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, expv, $time);
        end
    endtask

    // Compare every cycle, between edges.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(pix_vld_o == exp_vld, "R6 valid", pix_vld_o, exp_vld);
            check(pix_rgb_o == exp_rgb[23:0], "R3 R4 R5 R7 color", pix_rgb_o, exp_rgb);
            check(bus_rd_data == exp_rd, "R2 R5 readback", bus_rd_data, exp_rd);
        end
    end

    task automatic clear_in();
        bus_wr_en = 0; bus_rd_en = 0; pix_vld_i = 0;
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog expired");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) cyc();
        // R1: state under reset
        check(pix_vld_o == 0, "R1 valid in reset", pix_vld_o, 0);
        check(bus_rd_data == 0, "R1 readback in reset", bus_rd_data, 0);
        check(pix_rgb_o == 0, "R1 color in reset", pix_rgb_o, 0);
        rst_n = 1;
        // R1: memory reads as zero after reset
        for (int i = 0; i < 128; i += 17) begin
            bus_rd_en = 1; bus_rd_idx = 7'(i);
            pix_vld_i = 1; pix_idx_i = 8'(2 * i + 1);
            cyc();
        end
        clear_in();
        cyc();
        // R3 R4 R5: both halves carry the intensity bit
        bus_wr_en = 1; bus_wr_idx = 7'd5; bus_wr_data = 32'hFC1F_83E0;
        cyc();
        clear_in();
        pix_vld_i = 1; pix_idx_i = 8'd10;
        bus_rd_en = 1; bus_rd_idx = 7'd5;
        cyc();
        clear_in();
        pix_vld_i = 1; pix_idx_i = 8'd11;
        cyc();
        clear_in();
        cyc();
        check(pix_rgb_o == 24'hF800F8, "R3 R4 R5 odd entry", pix_rgb_o, 24'hF800F8);
        check(bus_rd_data == 32'hFC1F_83E0, "R2 R5 raw word", bus_rd_data, 32'hFC1F_83E0);
        // R7: same-cycle lookup sees old, next cycle sees new
        bus_wr_en = 1; bus_wr_idx = 7'd9; bus_wr_data = 32'h0000_7FFF;
        pix_vld_i = 1; pix_idx_i = 8'd18;
        bus_rd_en = 1; bus_rd_idx = 7'd9;
        cyc();
        check(pix_rgb_o == 0, "R7 same-cycle old color", pix_rgb_o, 0);
        check(bus_rd_data == 0, "R2 same-cycle old word", bus_rd_data, 0);
        clear_in();
        pix_vld_i = 1; pix_idx_i = 8'd18;
        cyc();
        check(pix_rgb_o == 24'hF8F8F8, "R7 next-cycle new color", pix_rgb_o, 24'hF8F8F8);
        clear_in();
        cyc();
        // R6: color holds with no request
        check(pix_vld_o == 0 && pix_rgb_o == 24'hF8F8F8, "R6 hold", pix_rgb_o, 24'hF8F8F8);
        // Random collisions on a narrow address set, then the full range
        for (int n = 0; n < 4000; n++) begin
            int unsigned span = (n < 2000) ? 3 : 127;
            bus_wr_en   = ($urandom_range(0, 2) == 0);
            bus_wr_idx  = 7'($urandom_range(0, span));
            bus_wr_data = $urandom();
            bus_rd_en   = ($urandom_range(0, 1) == 0);
            bus_rd_idx  = 7'($urandom_range(0, span));
            pix_vld_i   = ($urandom_range(0, 3) != 0);
            pix_idx_i   = 8'($urandom_range(0, 2 * span + 1));
            cyc();
        end
        clear_in();
        cyc();
        cyc();
        done = 1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule